// File: doc/BRIEF.md
# Keyed Amplitude Envelope Controller

This block shapes the amplitude envelope of a synthesized output. It produces a 14-bit amplitude scale code that rises from zero toward a programmed target and falls back to zero, under the control of a keying input. The rate of the ramp comes from two settings. A ramp tick is derived from the system clock through a programmable integer divider, and on each tick the amplitude moves by a power-of-two step of 1, 2, 4 or 8 codes.

The controller has three behaviours, chosen by a mode input. In manual mode the amplitude simply follows the target code. In ramp mode the keying input decides the direction of a saturating ramp. In pin mode the keying input switches the amplitude between zero and the target at once, with no steps in between.

While the block is enabled, its amplitude overrides every other amplitude source. The block takes the lower-priority amplitude in on `lower_amp_i` and passes it through unchanged while disabled. It also raises a pass-through flag in that state, and its own envelope is cleared.

Top module: `amp_key_ramp`

## Requirements
- R1: After reset, `env_amp_o` is 0, `pass_o` is 1 and `amp_o` equals `lower_amp_i`.
- R2: While `en_i` is low, `pass_o` is 1 and `amp_o` equals `lower_amp_i`. The envelope `env_amp_o` becomes 0 at the next clock edge.
- R3: While `en_i` is high, `pass_o` is 0 and `amp_o` equals `env_amp_o`, whatever the value of `lower_amp_i`.
- R4: Manual mode (`mode_i` = 0 or 3): one edge after an enabled cycle, `env_amp_o` equals the `target_i` of that cycle.
- R5: Pin mode (`mode_i` = 2): one edge after an enabled cycle, `env_amp_o` equals `target_i` if `key_i` was 1 in that cycle, and 0 if it was 0. No intermediate values appear.
- R6: Ramp mode (`mode_i` = 1): a ramp tick occurs once every `div_i`+1 clock cycles. The tick counter is cleared while the block is disabled, so the first tick after enabling falls on the (`div_i`+1)-th enabled cycle.
- R7: The ramp step is 1 << `step_sel_i`: codes 0, 1, 2 and 3 select steps of 1, 2, 4 and 8.
- R8: In ramp mode, on each tick the amplitude moves one step toward the goal and stops exactly at it. The goal is `target_i` when `key_i` is 1 and 0 when `key_i` is 0.
- R9: A change of `target_i` during a ramp takes effect at the next tick and does not reset the current amplitude. If the new target is below the current amplitude while `key_i` is 1, the amplitude ramps down to the new target.
- R10: In ramp mode, the amplitude holds its value on every cycle without a tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| en_i | input | 1 | Enables the envelope and gives it top amplitude priority |
| mode_i | input | 2 | 0/3 manual, 1 ramp, 2 pin-immediate |
| key_i | input | 1 | Keying input: 1 selects the target, 0 selects zero |
| target_i | input | 14 | Target amplitude code |
| step_sel_i | input | 2 | Ramp step exponent (step = 1 << value) |
| div_i | input | 16 | Ramp clock divider; tick period is value + 1 cycles |
| lower_amp_i | input | 14 | Amplitude from lower-priority sources |
| amp_o | output | 14 | Resolved amplitude code |
| env_amp_o | output | 14 | The block's own envelope amplitude |
| pass_o | output | 1 | 1 when lower-priority sources are in control |

## Verification
Two events often meet on the same cycle: a target change (or a reversal of the key) and a ramp tick. The new goal and the saturation must then both act on that one edge. The bench provokes this by changing the target mid-ramp, on a tick cycle and on a non-tick cycle. It judges the result against a cycle model built from R6 to R9, and against a closed-form check: the amplitude lands exactly on the target after ceil(target/step) ticks of `div_i`+1 cycles each. The bench also drops `en_i` on a cycle where a tick would have fired. There it checks that clearing the envelope wins over the step, and that control passes back to `lower_amp_i` in that same cycle.

// File: rtl/amp_key_pkg.sv
`timescale 1ns/1ps
package amp_key_pkg;

  typedef enum logic [1:0] {
    KM_DIRECT  = 2'd0,
    KM_RAMP    = 2'd1,
    KM_PIN     = 2'd2,
    KM_DIRECT2 = 2'd3
  } key_mode_e;

  localparam int STEP_W = 4;

  function automatic logic [STEP_W-1:0] step_of(input logic [1:0] sel);
    return STEP_W'(1) << sel;
  endfunction

endpackage

// File: rtl/amp_rst_sync.sv
`timescale 1ns/1ps
module amp_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/amp_tick_gen.sv
`timescale 1ns/1ps
module amp_tick_gen #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] cnt_d;
  logic             tick;

  always_comb begin
    tick = run_i && (cnt_q >= div_i);
    if (!run_i)    cnt_d = '0;
    else if (tick) cnt_d = '0;
    else           cnt_d = cnt_q + DIV_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign tick_o = tick;
endmodule

// File: rtl/amp_env_core.sv
`timescale 1ns/1ps
module amp_env_core
  import amp_key_pkg::*;
#(
  parameter int AMP_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic [1:0]       mode_i,
  input  logic             key_i,
  input  logic [AMP_W-1:0] target_i,
  input  logic [1:0]       step_sel_i,
  input  logic             tick_i,
  output logic [AMP_W-1:0] amp_o
);
  key_mode_e        mode;
  logic [AMP_W-1:0] amp_q;
  logic [AMP_W-1:0] amp_d;
  logic             amp_upd;
  logic [AMP_W-1:0] goal;
  logic [AMP_W-1:0] step;
  logic [AMP_W:0]   sum_up;
  logic [AMP_W-1:0] gap_dn;
  logic [AMP_W-1:0] ramp_nx;

  always_comb begin
    mode   = key_mode_e'(mode_i);
    goal   = key_i ? target_i : '0;
    step   = {{(AMP_W-STEP_W){1'b0}}, step_of(step_sel_i)};
    sum_up = {1'b0, amp_q} + {1'b0, step};
    gap_dn = amp_q - goal;
    if (amp_q < goal)
      ramp_nx = (sum_up >= {1'b0, goal}) ? goal : sum_up[AMP_W-1:0];
    else if (amp_q > goal)
      ramp_nx = (gap_dn <= step) ? goal : (amp_q - step);
    else
      ramp_nx = amp_q;
  end

  always_comb begin
    amp_d   = amp_q;
    amp_upd = 1'b0;
    if (!en_i) begin
      amp_d   = '0;
      amp_upd = 1'b1;
    end else begin
      unique case (mode)
        KM_RAMP: begin
          amp_d   = ramp_nx;
          amp_upd = tick_i;
        end
        KM_PIN: begin
          amp_d   = goal;
          amp_upd = 1'b1;
        end
        default: begin
          amp_d   = target_i;
          amp_upd = 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       amp_q <= '0;
    else if (amp_upd) amp_q <= amp_d;
  end

  assign amp_o = amp_q;
endmodule

// File: rtl/amp_src_sel.sv
`timescale 1ns/1ps
module amp_src_sel #(
  parameter int AMP_W = 14
) (
  input  logic             own_i,
  input  logic [AMP_W-1:0] env_i,
  input  logic [AMP_W-1:0] lower_i,
  output logic [AMP_W-1:0] amp_o,
  output logic             pass_o
);
  always_comb begin
    pass_o = !own_i;
    amp_o  = own_i ? env_i : lower_i;
  end
endmodule

// File: rtl/amp_key_ramp.sv
`timescale 1ns/1ps
module amp_key_ramp #(
  parameter int AMP_W = 14,
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic [1:0]       mode_i,
  input  logic             key_i,
  input  logic [AMP_W-1:0] target_i,
  input  logic [1:0]       step_sel_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic [AMP_W-1:0] lower_amp_i,
  output logic [AMP_W-1:0] amp_o,
  output logic [AMP_W-1:0] env_amp_o,
  output logic             pass_o
);
  logic rst_sync_n;
  logic ramp_tick;

  amp_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  amp_tick_gen #(.DIV_W(DIV_W)) u_tick (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .run_i  (en_i),
    .div_i  (div_i),
    .tick_o (ramp_tick)
  );

  amp_env_core #(.AMP_W(AMP_W)) u_core (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .en_i       (en_i),
    .mode_i     (mode_i),
    .key_i      (key_i),
    .target_i   (target_i),
    .step_sel_i (step_sel_i),
    .tick_i     (ramp_tick),
    .amp_o      (env_amp_o)
  );

  amp_src_sel #(.AMP_W(AMP_W)) u_sel (
    .own_i   (en_i),
    .env_i   (env_amp_o),
    .lower_i (lower_amp_i),
    .amp_o   (amp_o),
    .pass_o  (pass_o)
  );
endmodule

// File: rtl/amp_key_ramp_chk.sv
`timescale 1ns/1ps
module amp_key_ramp_chk #(
  parameter int AMP_W = 14
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en_i,
  input logic [1:0]       mode_i,
  input logic             key_i,
  input logic [AMP_W-1:0] target_i,
  input logic [AMP_W-1:0] lower_amp_i,
  input logic [AMP_W-1:0] amp_o,
  input logic [AMP_W-1:0] env_amp_o,
  input logic             pass_o,
  input logic             tick
);
  logic is_direct;
  logic is_ramp;
  logic is_pin;

  always_comb begin
    is_direct = (mode_i == 2'd0) || (mode_i == 2'd3);
    is_ramp   = (mode_i == 2'd1);
    is_pin    = (mode_i == 2'd2);
  end

  AST_OFF_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> env_amp_o == '0); // R2

  AST_OFF_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |-> (pass_o && amp_o == lower_amp_i)); // R2

  AST_ON_OWNS: assert property (@(posedge clk) disable iff (!rst_n)
    en_i |-> (!pass_o && amp_o == env_amp_o)); // R3

  AST_DIRECT_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && is_direct) |=> env_amp_o == $past(target_i)); // R4

  AST_PIN_LEVELS: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && is_pin) |=> env_amp_o == ($past(key_i) ? $past(target_i) : '0)); // R5

  AST_STEP_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && is_ramp && tick) |=>
      (((env_amp_o >= $past(env_amp_o)) ? (env_amp_o - $past(env_amp_o))
                                        : ($past(env_amp_o) - env_amp_o)) <= AMP_W'(8))); // R7

  AST_NO_OVERSHOOT: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && is_ramp && tick && key_i && env_amp_o <= target_i) |=>
      env_amp_o <= $past(target_i)); // R8

  AST_HOLD_OFF_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && is_ramp && !tick) |=> $stable(env_amp_o)); // R10
endmodule

bind amp_key_ramp amp_key_ramp_chk #(.AMP_W(AMP_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .en_i        (en_i),
  .mode_i      (mode_i),
  .key_i       (key_i),
  .target_i    (target_i),
  .lower_amp_i (lower_amp_i),
  .amp_o       (amp_o),
  .env_amp_o   (env_amp_o),
  .pass_o      (pass_o),
  .tick        (ramp_tick)
);

// File: tb/amp_key_ramp_test.sv
`timescale 1ns/1ps
module amp_key_ramp_test;
  localparam int AMP_W = 14;
  localparam int DIV_W = 16;

  logic             clk;
  logic             rst_n;
  logic             en_i;
  logic [1:0]       mode_i;
  logic             key_i;
  logic [AMP_W-1:0] target_i;
  logic [1:0]       step_sel_i;
  logic [DIV_W-1:0] div_i;
  logic [AMP_W-1:0] lower_amp_i;
  logic [AMP_W-1:0] amp_o;
  logic [AMP_W-1:0] env_amp_o;
  logic             pass_o;

  int n_cmp = 0;
  int n_bad = 0;
  int m_amp = 0;
  int m_cnt = 0;
  bit done  = 0;

  amp_key_ramp #(.AMP_W(AMP_W), .DIV_W(DIV_W)) uut (
    .clk         (clk),
    .rst_n       (rst_n),
    .en_i        (en_i),
    .mode_i      (mode_i),
    .key_i       (key_i),
    .target_i    (target_i),
    .step_sel_i  (step_sel_i),
    .div_i       (div_i),
    .lower_amp_i (lower_amp_i),
    .amp_o       (amp_o),
    .env_amp_o   (env_amp_o),
    .pass_o      (pass_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Cycle model from R2, R4-R9: applied once per rising edge.
  task automatic model_edge();
    bit tick;
    int goal;
    int stp;
    tick = en_i && (m_cnt >= int'(div_i));
    m_cnt = !en_i ? 0 : (tick ? 0 : m_cnt + 1);
    goal = key_i ? int'(target_i) : 0;
    stp  = 1 << step_sel_i;
    if (!en_i) m_amp = 0;
    else if (mode_i == 2'd2) m_amp = goal;
    else if (mode_i != 2'd1) m_amp = int'(target_i);
    else if (tick) begin
      if (m_amp < goal) m_amp = (m_amp + stp >= goal) ? goal : m_amp + stp;
      else if (m_amp > goal) m_amp = (m_amp - goal <= stp) ? goal : m_amp - stp;
    end
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      model_edge();
      @(negedge clk);
      if (!en_i) begin
        chk("R2 env", int'(env_amp_o), m_amp);
        chk("R2 amp_o", int'(amp_o), int'(lower_amp_i));
        chk("R2 pass_o", int'(pass_o), 1);
      end else begin
        if (mode_i == 2'd1)      chk("R8/R10 env", int'(env_amp_o), m_amp);
        else if (mode_i == 2'd2) chk("R5 env", int'(env_amp_o), m_amp);
        else                     chk("R4 env", int'(env_amp_o), m_amp);
        chk("R3 amp_o", int'(amp_o), m_amp);
        chk("R3 pass_o", int'(pass_o), 0);
      end
    end
  endtask

  initial begin
    #1600000;
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; en_i = 1'b0; mode_i = 2'd0; key_i = 1'b0;
    target_i = '0; step_sel_i = 2'd0; div_i = '0; lower_amp_i = 14'd777;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 env", int'(env_amp_o), 0);
    chk("R1 pass_o", int'(pass_o), 1);
    chk("R1 amp_o", int'(amp_o), 777);
    rst_n = 1'b1;
    run(4);

    // R4: manual mode sweep, both encodings
    en_i = 1'b1;
    for (int m = 0; m < 2; m++) begin
      mode_i = (m == 0) ? 2'd0 : 2'd3;
      for (int k = 0; k < 16; k++) begin
        target_i = AMP_W'((k * 1093) % 16384);
        lower_amp_i = AMP_W'(k * 31);
        run(1);
      end
      target_i = 14'd16383; run(1);
      chk("R4 full scale", int'(env_amp_o), 16383);
    end

    // R5: pin mode, key toggling
    mode_i = 2'd2;
    for (int k = 0; k < 24; k++) begin
      key_i = k[0] ^ k[2];
      target_i = AMP_W'(16383 - k * 500);
      run(1);
    end
    key_i = 1'b0; run(1);
    chk("R5 key low", int'(env_amp_o), 0);

    // R2: disable clears envelope, lower source passes
    en_i = 1'b0; lower_amp_i = 14'd4242; run(2);
    chk("R2 cleared", int'(env_amp_o), 0);

    // R6/R7/R8: ramp sweep over step and divider
    mode_i = 2'd1;
    for (int s = 0; s < 4; s++) begin
      for (int d = 0; d < 4; d++) begin
        for (int t = 0; t < 4; t++) begin
          int tv;
          int stp;
          int nt;
          tv  = (t == 0) ? 1 : (t == 1) ? 9 : (t == 2) ? 37 : 200;
          stp = 1 << s;
          nt  = (tv + stp - 1) / stp;
          en_i = 1'b0; run(2);
          step_sel_i = 2'(s); div_i = DIV_W'(d);
          target_i = AMP_W'(tv); key_i = 1'b1; en_i = 1'b1;
          if (d > 0) begin
            run(d);
            chk("R6 before first tick", int'(env_amp_o), 0);
          end
          run(1);
          chk("R7 first step", int'(env_amp_o), (stp < tv) ? stp : tv);
          run((nt - 1) * (d + 1));
          chk("R8 reaches target", int'(env_amp_o), tv);
          run(2 * (d + 1));
          chk("R8 holds at target", int'(env_amp_o), tv);
          key_i = 1'b0;
          run(nt * (d + 1) + d);
          chk("R8 reaches zero", int'(env_amp_o), 0);
        end
      end
    end

    // R8: full-scale ramp with largest step
    en_i = 1'b0; run(2);
    step_sel_i = 2'd3; div_i = '0; target_i = 14'd16383; key_i = 1'b1; en_i = 1'b1;
    run(2048);
    chk("R8 full scale", int'(env_amp_o), 16383);
    key_i = 1'b0; run(2048);
    chk("R8 back to zero", int'(env_amp_o), 0);

    // R9: target change mid-ramp
    en_i = 1'b0; run(2);
    step_sel_i = 2'd2; div_i = 16'd1; target_i = 14'd40; key_i = 1'b1; en_i = 1'b1;
    run(12);
    chk("R9 mid ramp", int'(env_amp_o), 24);
    target_i = 14'd10; run(2);
    chk("R9 no reset on change", int'(env_amp_o), 20);
    run(6);
    chk("R9 settles lower", int'(env_amp_o), 10);
    target_i = 14'd30; run(1);
    chk("R9 waits for tick", int'(env_amp_o), 10);
    run(9);
    chk("R9 settles higher", int'(env_amp_o), 30);

    // R2/R3: drop enable on a tick cycle, with lower source moving
    run(1);
    en_i = 1'b0; lower_amp_i = 14'd1234; run(1);
    chk("R2 disable wins over tick", int'(env_amp_o), 0);
    en_i = 1'b1; mode_i = 2'd0; target_i = 14'd5000;
    for (int k = 0; k < 8; k++) begin
      lower_amp_i = AMP_W'(k * 2000);
      run(1);
      chk("R3 priority", int'(amp_o), 5000);
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule